// File: doc/BRIEF.md
# Serial Flash Bus Pause Controller

This block decides when the slave side of a serial flash interface is paused by its active-low pause input. It samples chip select, the serial clock and the pause pin through synchronisers into the system clock domain. It produces a held flag that freezes the bit-shift logic and turns off the serial output driver. While the flag is set, the instruction, address and buffered data in the neighbouring shift logic stay as they are, so a transfer carries on from the bit where it stopped.

A change on the pause pin takes effect only while the serial clock is low. If the pin moves while the clock is high, the change waits until the clock next falls. A one-bit pending flag records that a change is waiting. The function needs chip select to be active. It switches itself off when the pin is configured as a fourth data line (quad enable set) or as a reset input (pin-function select set). If chip select is released while paused, the pause ends and a one-cycle transaction-reset pulse goes to the front end.

Top module: `spi_hold_unit`

## Requirements
- R1: After reset, held_o is 0 and txn_rst_o is 0, and sdo_oe_o equals sdo_oe_req_i.
- R2: The held state never begins while chip select (cs_n_i) is high (inactive).
- R3: Pin inputs pass a two-stage synchroniser. If sclk_i is low and hold_n_i falls while cs_n_i is low and the function is enabled, held_o becomes 1 on the third rising system clock edge after the change, and not before.
- R4: If hold_n_i falls while sclk_i is high, held_o stays 0 until sclk_i goes low. It then becomes 1 three system clock edges after the clock falls.
- R5: If hold_n_i rises while sclk_i is low, held_o returns to 0 on the third rising system clock edge.
- R6: If hold_n_i rises while sclk_i is high, held_o stays 1 until sclk_i goes low. It then returns to 0 three edges later.
- R7: While held_o is 1, sdo_oe_o is 0 whatever the value of sdo_oe_req_i.
- R8: sclk_rise_o and sclk_fall_o each pulse for one cycle on a synchronised serial clock edge while cs_n_i is low. They are suppressed while held_o is 1.
- R9: While quad_en_i is 1, held_o is 0 one cycle later and stays 0, whatever hold_n_i does.
- R10: While hold_rst_sel_i is 1, held_o is 0 one cycle later and stays 0, whatever hold_n_i does.
- R11: If chip select rises while held, held_o clears and txn_rst_o pulses high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select pin, active low, asynchronous |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| hold_n_i | input | 1 | Pause pin, active low, asynchronous |
| quad_en_i | input | 1 | Quad enable configuration bit; 1 disables the pause function |
| hold_rst_sel_i | input | 1 | Pin-function select; 1 means reset use, which disables the pause function |
| sdo_oe_req_i | input | 1 | Output-enable request from the shift logic |
| held_o | output | 1 | Held flag, freezes the shift logic |
| txn_rst_o | output | 1 | One-cycle pulse: chip select released while held |
| sdo_oe_o | output | 1 | Gated serial output enable |
| sclk_rise_o | output | 1 | Synchronised serial clock rising edge, gated |
| sclk_fall_o | output | 1 | Synchronised serial clock falling edge, gated |

## Verification
The hardest case is a pause change made while the serial clock is high. The pin must sit unchanged until the clock falls, and a pin that reverts before that fall must leave the state untouched. Directed sequences hold the clock high across many system cycles around a pause edge, then lower it. Random stimulus toggles the clock and the pause pin independently at similar rates, so that reversals inside the high phase occur often. The results are compared against a cycle model of the synchroniser delay in the bench.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic hold_n;
  } pin_t;

  localparam int unsigned PIN_W = $bits(pin_t);
  localparam logic [PIN_W-1:0] PIN_IDLE = 3'b101;  // deselected, clock low, not paused
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[s] <= RST_VAL;
      end else if (s == 0) begin
        stg_q[s] <= d_i;
      end else begin
        stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= s_i;
  end

  assign rise_o = s_i & ~prev_q;
  assign fall_o = ~s_i & prev_q;
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic hold_n_i,
  output logic held_o,
  output logic pending_o,
  output logic txn_rst_o
);
  logic held_q, held_d;
  logic pend_q, pend_d;
  logic txn_q, txn_d;
  logic cs_prev_q;
  logic want;

  assign want = en_i & ~cs_n_i & ~hold_n_i;

  always_comb begin
    held_d = held_q;
    if (!en_i || cs_n_i)                 held_d = 1'b0;
    else if (want != held_q && !sclk_i)  held_d = want;  // apply only in clock low phase
    pend_d = en_i & ~cs_n_i & (want != held_q) & sclk_i;
    txn_d  = held_q & cs_n_i & ~cs_prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q    <= 1'b0;
      pend_q    <= 1'b0;
      txn_q     <= 1'b0;
      cs_prev_q <= 1'b1;
    end else begin
      held_q    <= held_d;
      pend_q    <= pend_d;
      txn_q     <= txn_d;
      cs_prev_q <= cs_n_i;
    end
  end

  assign held_o    = held_q;
  assign pending_o = pend_q;
  assign txn_rst_o = txn_q;

  a_r2_entry_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !$past(held_q)) |-> !$past(cs_n_i));
  a_r4_entry_clk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !$past(held_q)) |-> !$past(sclk_i));
  a_r6_exit_clk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(held_q) && $past(en_i && !cs_n_i)) |-> !$past(sclk_i));
  a_r4_pending_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> $stable(held_q));
  a_r11_txn_clears_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_q |-> !held_q);
endmodule

// File: rtl/spi_hold_unit.sv
module spi_hold_unit
  import spi_hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic hold_n_i,
  input  logic quad_en_i,
  input  logic hold_rst_sel_i,
  input  logic sdo_oe_req_i,
  output logic held_o,
  output logic txn_rst_o,
  output logic sdo_oe_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o
);
  pin_t pin_raw, pin_s;
  logic en, held, pending, s_rise, s_fall;

  assign pin_raw = '{cs_n: cs_n_i, sclk: sclk_i, hold_n: hold_n_i};
  assign en      = ~quad_en_i & ~hold_rst_sel_i;

  spi_hold_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_raw), .q_o(pin_s)
  );

  spi_hold_edge #(.RST_VAL(1'b0)) i_sclk_edge (
    .clk_i, .rst_ni, .s_i(pin_s.sclk), .rise_o(s_rise), .fall_o(s_fall)
  );

  spi_hold_ctrl i_ctrl (
    .clk_i, .rst_ni,
    .en_i(en), .cs_n_i(pin_s.cs_n), .sclk_i(pin_s.sclk), .hold_n_i(pin_s.hold_n),
    .held_o(held), .pending_o(pending), .txn_rst_o
  );

  assign held_o      = held;
  assign sdo_oe_o    = sdo_oe_req_i & ~held;
  assign sclk_rise_o = s_rise & ~held & ~pin_s.cs_n;
  assign sclk_fall_o = s_fall & ~held & ~pin_s.cs_n;

  a_r9_quad_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quad_en_i |=> !held_o);
  a_r10_rst_sel_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_rst_sel_i |=> !held_o);
  a_r4_pending_not_with_txn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending |-> !txn_rst_o);
endmodule

// File: tb/test_spi_hold_unit.sv
`timescale 1ns/1ps
module test_spi_hold_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, hold_n = 1'b1, quad = 1'b0, rsel = 1'b0, oe_req = 1'b0;
  logic held, txn, sdo_oe, s_rise, s_fall;
  int total = 0, bad = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;
  int txn_cnt = 0, rise_cnt = 0;

  always #10 clk = ~clk;

  spi_hold_unit i_spi_hold_unit (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .hold_n_i(hold_n),
    .quad_en_i(quad), .hold_rst_sel_i(rsel), .sdo_oe_req_i(oe_req),
    .held_o(held), .txn_rst_o(txn), .sdo_oe_o(sdo_oe),
    .sclk_rise_o(s_rise), .sclk_fall_o(s_fall)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference: two-stage delay then clock-low-aligned update
  logic [2:0] m1 = 3'b101, m2 = 3'b101;
  logic m3_cs = 1'b1, m3_sclk = 1'b0, m_held = 1'b0, m_txn = 1'b0;

  function automatic logic next_held(logic en, logic cs2, logic sclk2, logic hold2, logic h);
    logic want;
    want = en & ~cs2 & ~hold2;
    if (!en || cs2) return 1'b0;
    if (want != h && !sclk2) return want;
    return h;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m1 = 3'b101; m2 = 3'b101; m3_cs = 1'b1; m3_sclk = 1'b0; m_held = 1'b0; m_txn = 1'b0;
    end else begin
      logic nh, nt;
      nh = next_held(~quad & ~rsel, m2[2], m2[1], m2[0], m_held);
      nt = m_held & m2[2] & ~m3_cs;
      m3_cs = m2[2]; m3_sclk = m2[1];
      m2 = m1; m1 = {cs_n, sclk, hold_n};
      m_held = nh; m_txn = nt;
    end
    #5;
    if (txn === 1'b1) txn_cnt++;
    if (s_rise === 1'b1) rise_cnt++;
    if (cmp_en) begin
      chk("R4 held vs model", held, m_held);
      chk("R11 txn vs model", txn, m_txn);
      chk("R7 sdo_oe vs model", sdo_oe, oe_req & ~m_held);
      chk("R8 rise vs model", s_rise, m2[1] & ~m3_sclk & ~m_held & ~m2[2]);
      chk("R8 fall vs model", s_fall, ~m2[1] & m3_sclk & ~m_held & ~m2[2]);
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_5eed));
    tick(3);
    oe_req = 1'b1;
    #1;
    chk("R1 held after reset", held, 1'b0);
    chk("R1 txn after reset", txn, 1'b0);
    chk("R1 sdo_oe follows request", sdo_oe, 1'b1);
    rst_n = 1'b1;
    tick(3);

    // R3: entry with clock low
    cs_n = 1'b0; tick(4);
    hold_n = 1'b0; tick(2);
    chk("R3 not yet held after 2 edges", held, 1'b0);
    tick(1);
    chk("R3 held on third edge", held, 1'b1);
    chk("R7 sdo_oe off while held", sdo_oe, 1'b0);

    // R8: clock edges swallowed while held
    rise_cnt = 0;
    for (int i = 0; i < 4; i++) begin
      sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
    end
    chk("R8 no rise pulses while held", rise_cnt == 0, 1'b1);

    // R5: exit with clock low
    hold_n = 1'b1; tick(2);
    chk("R5 still held after 2 edges", held, 1'b1);
    tick(1);
    chk("R5 released on third edge", held, 1'b0);

    // R8: edges pass when not held
    rise_cnt = 0;
    sclk = 1'b1; tick(5); sclk = 1'b0; tick(5);
    chk("R8 one rise pulse when free", rise_cnt == 1, 1'b1);

    // R4: entry with clock high waits for fall
    sclk = 1'b1; tick(4);
    hold_n = 1'b0; tick(8);
    chk("R4 no entry while clock high", held, 1'b0);
    sclk = 1'b0; tick(2);
    chk("R4 not yet after fall", held, 1'b0);
    tick(1);
    chk("R4 entry after clock fall", held, 1'b1);

    // R6: exit with clock high waits for fall
    sclk = 1'b1; tick(4);
    hold_n = 1'b1; tick(8);
    chk("R6 still held while clock high", held, 1'b1);
    sclk = 1'b0; tick(3);
    chk("R6 exit after clock fall", held, 1'b0);

    // R4: reversal inside high phase leaves state alone
    sclk = 1'b1; tick(4);
    hold_n = 1'b0; tick(4); hold_n = 1'b1; tick(4);
    sclk = 1'b0; tick(6);
    chk("R4 reverted pause ignored", held, 1'b0);

    // R11: chip select released while held
    hold_n = 1'b0; tick(4);
    chk("R11 held before release", held, 1'b1);
    txn_cnt = 0;
    cs_n = 1'b1; tick(8);
    chk("R11 held cleared", held, 1'b0);
    chk("R11 single txn pulse", txn_cnt == 1, 1'b1);

    // R2: no entry with chip select high
    tick(8);
    chk("R2 no hold while deselected", held, 1'b0);
    cs_n = 1'b0; tick(4);
    chk("R2 hold once selected", held, 1'b1);

    // R9: quad enable disables
    quad = 1'b1; tick(1);
    chk("R9 quad clears held", held, 1'b0);
    tick(6);
    chk("R9 stays clear with pin low", held, 1'b0);
    quad = 1'b0; tick(2);
    chk("R9 resumes after quad off", held, 1'b1);

    // R10: reset-select disables
    rsel = 1'b1; tick(1);
    chk("R10 select clears held", held, 1'b0);
    tick(6);
    chk("R10 stays clear with pin low", held, 1'b0);
    rsel = 1'b0; hold_n = 1'b1; tick(6);

    // random phase against model
    cmp_en = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 30) sclk = ~sclk;
      else if (r < 45) hold_n = ~hold_n;
      else if (r < 49) cs_n = ~cs_n;
      else if (r < 51) quad = ($urandom_range(0, 7) == 0);
      else if (r < 53) rsel = ($urandom_range(0, 7) == 0);
      else if (r < 60) oe_req = ~oe_req;
      tick(int'($urandom_range(1, 4)));
    end
    cmp_en = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule